// File: doc/BRIEF.md
# Lock-gated processor reset sequencer

This block produces the reset line for a processor from two conditions: an external, asynchronous, active-low reset request and the lock flag of the clock generator that feeds the processor. The pad is open-drain. The block only chooses between pulling the pad low and leaving it floating, and an external pull-up supplies the high level. A low request pulls the pad low at once, with no clock edge involved. Once the request is removed, the pad is held low for a fixed stretch of output-clock cycles and is then released, provided the loop stays locked for the whole stretch.

The rising edge of the request is moved into the output-clock domain through a short flop chain. Only after that chain does the hold counter start to run. The two-cycle delay of the chain is part of the hold window: with the defaults, the pad is released on the 1024th rising clock edge after the request rises. The lock flag is taken as synchronous to the output clock, because that clock comes from the same loop. Losing lock pulls the pad low at once and clears the count, so the pad also acts as a lock indicator. A separate status output reports the released state. An active-low power-on reset returns everything to the pulling state.

Top module: `rst_seq_top`

## Requirements
- R1: While `req_n` is low, `pad_oe` is 1 and `lock_stat` is 0 within the same clock period, with no clock edge needed. This also holds for a low pulse shorter than one clock period that falls between two edges.
- R2: With `locked` high and `por_n` high, a rise of `req_n` (including the rise that ends a short pulse) leads to this sequence: `pad_oe` stays 1 through the first HOLD_CYC-1 rising edges after the rise and becomes 0 after the HOLD_CYC-th edge (1024 by default). This is SYNC_STAGES synchroniser edges plus HOLD_CYC-SYNC_STAGES counting edges.
- R3: With `req_n` high since power-on and `locked` low, `pad_oe` stays 1 for as long as lock is absent. When `locked` rises, `pad_oe` becomes 0 after the (HOLD_CYC-SYNC_STAGES)-th rising edge that samples `locked` high (1022 by default).
- R4: If `locked` falls while the hold count is running, `pad_oe` becomes 1 at once. The count is cleared on the next edge. When lock returns, the full (HOLD_CYC-SYNC_STAGES)-edge count starts again from zero.
- R5: If `locked` falls after release, `pad_oe` becomes 1 and `lock_stat` becomes 0 at once, with no clock edge needed.
- R6: The encoding of `pad_oe` is: 1 means the pad is pulled low, 0 means it is high impedance. No state of the block drives the pad high. While `por_n` is high, `lock_stat` is 1 exactly when `pad_oe` is 0.
- R7: While `por_n` is low, `pad_oe` is 1 and the synchroniser and counter are cleared. After `por_n` rises with `req_n` and `locked` high, release follows the same HOLD_CYC-edge timing as R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-rate clock from the loop |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| req_n | input | 1 | External reset request, active low, asynchronous |
| locked | input | 1 | Loop lock flag, synchronous to clk |
| pad_oe | output | 1 | Open-drain enable: 1 pulls the reset pad low, 0 floats it |
| lock_stat | output | 1 | 1 when the reset is released and the loop is locked |

## Verification
The release timing is tried from several different starting points:
- The rise of the request with lock already present. Here the count includes the synchroniser stages.
- The arrival of lock while the request has been high since power-on. Here the count excludes them.
- The return of lock after a drop part way through the count.
- The rise of power-on reset.

In each case the pad is sampled one edge before the expected release and again at the release edge. This separates an off-by-one count, a count that leaves out the synchroniser, and a count that is not cleared by a drop.

A request pulse shorter than a clock period that falls between edges, and a lock drop after release, are both checked within the same period. This shows that assertion does not wait for a clock. A request held low for a long time shows that the counter cannot run while the request is asserted.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    // Open-drain pad: either pulling low or floating; never driving high.
    typedef enum logic {
        PAD_FLOAT = 1'b0,
        PAD_PULL  = 1'b1
    } pad_e;

    function automatic pad_e pad_of(input logic released);
        return released ? PAD_FLOAT : PAD_PULL;
    endfunction

endpackage

// File: rtl/rst_req_sync.sv
// Brings the release (rising) edge of an asynchronous clear into the clk
// domain; assertion is asynchronous through clr_n.
module rst_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr_n,
    output logic synced
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            sh_d[i] = sh_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign synced = sh_q[STAGES-1];

endmodule

// File: rtl/rst_hold_ctr.sv
// Counts edges on which run is high; sets released after COUNT_N of them.
// Any edge with run low clears both the count and the released flag.
module rst_hold_ctr #(
    parameter int COUNT_N = 1022
) (
    input  logic clk,
    input  logic clr_n,
    input  logic run,
    output logic released
);

    localparam int CW = (COUNT_N < 2) ? 1 : $clog2(COUNT_N + 1);
    localparam logic [CW-1:0] LAST = CW'(COUNT_N - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rel;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d.cnt = '0;
            st_d.rel = 1'b0;
        end else if (!st_q.rel) begin
            if (st_q.cnt == LAST) begin
                st_d.rel = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign released = st_q.rel;

endmodule

// File: rtl/rst_seq_top.sv
module rst_seq_top #(
    parameter int HOLD_CYC    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic req_n,
    input  logic locked,
    output logic pad_oe,
    output logic lock_stat
);

    import rst_seq_pkg::*;

    localparam int COUNT_N = HOLD_CYC - SYNC_STAGES;

    logic   arst_n;
    logic   req_synced;
    logic   released;
    pad_e   pad_state;

    // Either a power-on reset or a request clears the whole sequence.
    assign arst_n = por_n & req_n;

    rst_req_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .clr_n  (arst_n),
        .synced (req_synced)
    );

    rst_hold_ctr #(
        .COUNT_N (COUNT_N)
    ) u_ctr (
        .clk      (clk),
        .clr_n    (arst_n),
        .run      (req_synced & locked),
        .released (released)
    );

    // Asynchronous terms give immediate assertion, without any edge.
    assign pad_state = pad_of(released & locked & arst_n);
    assign pad_oe    = (pad_state == PAD_PULL);
    assign lock_stat = (pad_state == PAD_FLOAT);

endmodule

// File: rtl/rst_seq_chk.sv
module rst_seq_chk #(
    parameter int HOLD_CYC    = 1024,
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic por_n,
    input logic req_n,
    input logic locked,
    input logic pad_oe,
    input logic lock_stat
);

    localparam int COUNT_N = HOLD_CYC - SYNC_STAGES;
    localparam int KW      = $clog2(HOLD_CYC + 1);

    logic          ck_rst_n;
    logic [KW-1:0] ck_q;

    assign ck_rst_n = por_n & req_n;

    // Consecutive edges with lock present since the last request/power-on.
    always_ff @(posedge clk or negedge ck_rst_n) begin
        if (!ck_rst_n) begin
            ck_q <= '0;
        end else if (locked) begin
            if (ck_q != KW'(HOLD_CYC)) begin
                ck_q <= ck_q + KW'(1);
            end
        end else begin
            ck_q <= '0;
        end
    end

    // R1
    req_assert_chk: assert property (@(posedge clk) disable iff (!por_n)
        !req_n |-> (pad_oe && !lock_stat));

    // R5
    lock_loss_chk: assert property (@(posedge clk) disable iff (!por_n)
        !locked |-> (pad_oe && !lock_stat));

    // R7
    por_force_chk: assert property (@(posedge clk)
        !por_n |-> pad_oe);

    // R3
    no_early_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        lock_stat |-> (ck_q >= KW'(COUNT_N)));

    // R2
    timely_release_chk: assert property (@(posedge clk) disable iff (!por_n)
        ((ck_q >= KW'(HOLD_CYC)) && locked && req_n) |-> lock_stat);

    // R4
    release_needs_lock_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(lock_stat) |-> $past(locked));

endmodule

bind rst_seq_top rst_seq_chk #(
    .HOLD_CYC    (HOLD_CYC),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (.*);

// File: tb/sim_rst_seq_top.sv
`timescale 1ns/1ps
module sim_rst_seq_top;

    localparam int HOLD_CYC    = 1024;
    localparam int SYNC_STAGES = 2;
    localparam int COUNT_N     = HOLD_CYC - SYNC_STAGES;

    logic clk = 1'b0;
    logic por_n, req_n, locked;
    logic pad_oe, lock_stat;

    int checks = 0;
    int errors = 0;

    rst_seq_top #(
        .HOLD_CYC    (HOLD_CYC),
        .SYNC_STAGES (SYNC_STAGES)
    ) u0 (
        .clk       (clk),
        .por_n     (por_n),
        .req_n     (req_n),
        .locked    (locked),
        .pad_oe    (pad_oe),
        .lock_stat (lock_stat)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // Away from the rising edge, before the next one.
    task automatic mid();
        @(negedge clk);
        #0.5;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // After a trigger in mid-cycle: held through n-1 edges, released at edge n.
    task automatic expect_release(input string tag, input int n);
        edges(n - 1);
        chk({tag, " held before last edge"}, pad_oe, 1'b1);
        edges(1);
        chk({tag, " released at last edge"}, pad_oe, 1'b0);
        chk({tag, " R6 status on release"}, lock_stat, 1'b1);
    endtask

    task automatic t_powerup_nolock();
        #1;
        chk("R7 pad pulled in power-on reset", pad_oe, 1'b1);
        chk("R6 status low in power-on reset", lock_stat, 1'b0);
        edges(3);
        mid();
        por_n = 1'b1;
        edges(3000);
        chk("R3 held while lock absent", pad_oe, 1'b1);
        mid();
        locked = 1'b1;
        expect_release("R3 lock arrival", COUNT_N);
    endtask

    task automatic t_por();
        mid();
        por_n = 1'b0;
        #1;
        chk("R7 immediate pull on power-on reset", pad_oe, 1'b1);
        edges(3);
        mid();
        por_n = 1'b1;
        expect_release("R7 after power-on reset", HOLD_CYC);
    endtask

    task automatic t_short_pulse();
        mid();
        req_n = 1'b0;
        #0.5;
        chk("R1 pull during short pulse", pad_oe, 1'b1);
        chk("R1 status low during short pulse", lock_stat, 1'b0);
        #0.5;
        req_n = 1'b1;
        expect_release("R2 after short pulse", HOLD_CYC);
    endtask

    task automatic t_long_request();
        mid();
        req_n = 1'b0;
        edges(2000);
        chk("R1 held during long request", pad_oe, 1'b1);
        mid();
        req_n = 1'b1;
        expect_release("R2 after long request", HOLD_CYC);
    endtask

    task automatic t_lock_drops();
        mid();
        locked = 1'b0;
        #0.5;
        chk("R5 immediate pull on lock loss", pad_oe, 1'b1);
        chk("R5 status low on lock loss", lock_stat, 1'b0);
        edges(3);
        mid();
        locked = 1'b1;
        edges(500);
        chk("R4 held mid count", pad_oe, 1'b1);
        mid();
        locked = 1'b0;
        #0.5;
        chk("R4 pull on lock loss in count", pad_oe, 1'b1);
        edges(3);
        mid();
        locked = 1'b1;
        expect_release("R4 full recount", COUNT_N);
    endtask

    initial begin
        por_n  = 1'b0;
        req_n  = 1'b1;
        locked = 1'b0;
        t_powerup_nolock();
        t_por();
        t_short_pulse();
        t_long_request();
        t_lock_drops();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule